// File: doc/BRIEF.md
# Single-Frame Transmit DMA Engine

This block moves one frame from system memory to a MAC transmit path. Software first programs a frame start address. It then writes a frame length. Writing a nonzero length while the engine is idle starts the transfer. The engine fetches the frame as 32-bit words, one bus request at a time, and presents the bytes as a byte stream with valid/ready handshaking. A last-byte marker is raised on the final byte. The final word is cut short when the length is not a multiple of four.

While a frame is in flight, reading the length register gives the number of bytes not yet accepted downstream. That value falls to zero as the frame drains. A status register has two bits. One shows whether the engine can accept a new address and length. The other shows that a frame has finished, and software clears it by writing 1. Software polls the ready bit before it programs the next frame. Framing, preamble, CRC and collision handling are left to the MAC.

Top module: `txdma_top`

## Requirements
- R1: After reset the status register reads ready=1 and done=0, the length register reads 0, and txValid and memReq are low.
- R2: A write to offset 0 while idle stores the start address rounded down to a word boundary (bits 1:0 forced to 0). Offset 0 reads back the stored value.
- R3: A write to offset 1 with a nonzero value in bits 10:0 while idle starts a frame of that many bytes at the stored address. The status ready bit reads 0 from the next cycle on.
- R4: A length write of zero is ignored. Writes to offset 0 or offset 1 while a frame is in progress are ignored. The stored address and the remaining count stay unchanged, and no transfer starts.
- R5: Memory is read one word per request. memReq stays high with memAddr stable until memValid returns the word. Successive requests of a frame use addresses that rise by 4 from the start address.
- R6: Bytes leave in little-endian order within each word, which means bits 7:0 go first. Exactly length bytes are sent, so the last word gives only length mod 4 bytes (all four when that is 0).
- R7: txLast is high together with txValid on the final byte of a frame and on no other byte.
- R8: While txValid is high and txReady is low, txValid, txData and txLast hold their values.
- R9: Offset 1 reads the count of bytes not yet accepted. The count drops by one on each cycle with txValid and txReady both high, and it reads 0 once the frame is done.
- R10: Status bit 1 (done) is set in the cycle after the final byte is accepted. A status write with bit 1 set clears it, but a set in the same cycle takes priority over the clear.
- R11: Status bit 0 (ready) reads 1 exactly when no frame is in progress. Offset 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | 2 | Write offset: 0 address, 1 length, 2 status |
| regWrData | input | 32 | Write data |
| regRdAddr | input | 2 | Read offset, combinational read |
| regRdData | output | 32 | Read data |
| memReq | output | 1 | Word read request, held until memValid |
| memAddr | output | 32 | Word-aligned read address |
| memValid | input | 1 | Read data valid, ends the request |
| memRdData | input | 32 | Read word |
| txData | output | 8 | Stream byte |
| txValid | output | 1 | Stream byte valid |
| txLast | output | 1 | Final byte of the frame |
| txReady | input | 1 | Downstream accepts the byte |

## Verification
The bench runs lengths of 1, 4 and 5 bytes, and also lengths of one to three bytes past a word boundary and the 11-bit maximum. These expose an engine that always emits whole words, or one that drops the tail of the final word. Random memory latency and stalls on txReady catch data that moves during a stall, a request that drops early, and a remaining count that steps on stalled cycles. Address and length writes made while a frame is in flight, plus a zero-length write, catch an engine that restarts or retargets itself. A done-clear write issued just as a frame finishes checks the set-over-clear priority.

// File: rtl/txdma_pkg.sv
package txdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_SEND} txState_e;

  typedef struct packed {
    logic loadAddr;
    logic loadLen;
    logic captureWord;
    logic byteSent;
    logic setDone;
    logic clearDone;
  } dpStrobe_t;

  localparam logic [1:0] OFS_ADDR = 2'd0;
  localparam logic [1:0] OFS_LEN  = 2'd1;
  localparam logic [1:0] OFS_STAT = 2'd2;
endpackage

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              memValid,
  input  logic              txReady,
  input  logic              remOne,
  input  logic              wordEnd,
  output dpStrobe_t         strb,
  output logic              memReq,
  output logic              txValid,
  output logic              engineIdle
);
  txState_e state, nextState;
  logic lenNonZero;

  assign lenNonZero = |regWrData[LEN_W-1:0];
  assign engineIdle = (state == ST_IDLE);
  assign memReq     = (state == ST_FETCH);
  assign txValid    = (state == ST_SEND);

  always_comb begin
    nextState = state;
    strb = '0;
    strb.clearDone = regWrEn && (regWrAddr == OFS_STAT) && regWrData[1];
    case (state)
      ST_IDLE: begin
        strb.loadAddr = regWrEn && (regWrAddr == OFS_ADDR);
        if (regWrEn && (regWrAddr == OFS_LEN) && lenNonZero) begin
          strb.loadLen = 1'b1;
          nextState = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (memValid) begin
          strb.captureWord = 1'b1;
          nextState = ST_SEND;
        end
      end
      ST_SEND: begin
        if (txReady) begin
          strb.byteSent = 1'b1;
          if (remOne) begin
            strb.setDone = 1'b1;
            nextState = ST_IDLE;
          end else if (wordEnd) begin
            nextState = ST_FETCH;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R5
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq);

  // R3
  start_leaves_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    engineIdle && regWrEn && (regWrAddr == OFS_LEN) && lenNonZero |=> memReq);
endmodule

// File: rtl/txdma_dp.sv
module txdma_dp
  import txdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [1:0]        regRdAddr,
  input  logic [DATA_W-1:0] memRdData,
  input  logic              engineIdle,
  input  logic              txValid,
  input  logic              txReady,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        txData,
  output logic              txLast,
  output logic              remOne,
  output logic              wordEnd
);
  localparam int LANES = DATA_W / 8;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [ADDR_W-1:0] addrReg, wordPtr;
  logic [DATA_W-1:0] wordBuf;
  logic [IDX_W-1:0]  byteIdx;
  logic [LEN_W-1:0]  remaining;
  logic              doneFlag;
  logic [7:0]        lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = wordBuf[8*g +: 8];
  end

  assign txData  = lane[byteIdx];
  assign remOne  = (remaining == LEN_W'(1));
  assign wordEnd = (byteIdx == IDX_W'(LANES-1));
  assign txLast  = txValid && remOne;
  assign memAddr = wordPtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg   <= '0;
      wordPtr   <= '0;
      wordBuf   <= '0;
      byteIdx   <= '0;
      remaining <= '0;
      doneFlag  <= 1'b0;
    end else begin
      if (strb.loadAddr)
        addrReg <= {regWrData[ADDR_W-1:IDX_W], {IDX_W{1'b0}}};
      if (strb.loadLen) begin
        remaining <= regWrData[LEN_W-1:0];
        wordPtr   <= addrReg;
        byteIdx   <= '0;
      end
      if (strb.captureWord)
        wordBuf <= memRdData;
      if (strb.byteSent) begin
        remaining <= remaining - LEN_W'(1);
        byteIdx   <= byteIdx + IDX_W'(1);
        if (wordEnd)
          wordPtr <= wordPtr + ADDR_W'(LANES);
      end
      if (strb.setDone)        doneFlag <= 1'b1;
      else if (strb.clearDone) doneFlag <= 1'b0;
    end
  end

  always_comb begin
    case (regRdAddr)
      OFS_ADDR: regRdData = DATA_W'(addrReg);
      OFS_LEN:  regRdData = DATA_W'(remaining);
      OFS_STAT: regRdData = DATA_W'({doneFlag, engineIdle});
      default:  regRdData = '0;
    endcase
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid && $stable(txData) && $stable(txLast));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady |=> remaining == $past(remaining) - LEN_W'(1));

  // R7
  last_ends_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && txReady && txLast |=> engineIdle);

  // R10
  done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneFlag) |-> $past(txValid && txReady && txLast));

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !engineIdle && !txValid && !strb.captureWord |=> $stable(memAddr));

  // R11
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    engineIdle |-> remaining == '0);
endmodule

// File: rtl/txdma_top.sv
module txdma_top
  import txdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrAddr,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [1:0]        regRdAddr,
  output logic [DATA_W-1:0] regRdData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memValid,
  input  logic [DATA_W-1:0] memRdData,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txLast,
  input  logic              txReady
);
  dpStrobe_t strb;
  logic remOne, wordEnd, engineIdle;

  txdma_ctrl #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .memValid(memValid), .txReady(txReady),
    .remOne(remOne), .wordEnd(wordEnd), .strb(strb), .memReq(memReq),
    .txValid(txValid), .engineIdle(engineIdle)
  );

  txdma_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .memRdData(memRdData), .engineIdle(engineIdle),
    .txValid(txValid), .txReady(txReady), .regRdData(regRdData),
    .memAddr(memAddr), .txData(txData), .txLast(txLast),
    .remOne(remOne), .wordEnd(wordEnd)
  );
endmodule

// File: tb/sim_txdma_top.sv
`timescale 1ns/1ps
module sim_txdma_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrAddr = 2'd0;
  logic [31:0] regWrData = 32'd0;
  logic [1:0] regRdAddr = 2'd0;
  logic [31:0] regRdData;
  logic memReq, memValid = 1'b0;
  logic [31:0] memAddr, memRdData = 32'd0;
  logic [7:0] txData;
  logic txValid, txLast;
  logic txReady = 1'b1;

  int tests = 0, fails = 0, cycles = 0;
  int readyMode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  logic [7:0] expQ[$];
  int mRem = 0, mLen = 0;
  logic [31:0] mAddr = 0, mBase = 0;
  logic mDone = 1'b0;

  always #2 clk = ~clk;

  txdma_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid),
    .memRdData(memRdData), .txData(txData), .txValid(txValid),
    .txLast(txLast), .txReady(txReady)
  );

  function automatic logic [7:0] patByte(logic [31:0] b);
    return 8'((b * 37) ^ (b >> 8) ^ 32'h5A);
  endfunction

  function automatic logic [31:0] memWord(logic [31:0] a);
    return {patByte(a + 3), patByte(a + 2), patByte(a + 1), patByte(a)};
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // memory responder with pseudo-random latency
  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memValid <= memReq && !memValid && lfsr[0];
    memRdData <= memWord(memAddr);
  end

  // downstream ready pattern
  always @(negedge clk) begin
    case (readyMode)
      0: txReady <= 1'b1;
      1: txReady <= lfsr[3];
      default: txReady <= ~txReady;
    endcase
  end

  // read address cycles over all offsets
  always @(negedge clk) regRdAddr <= regRdAddr + 2'd1;

  // per-cycle compare and model update
  initial begin
    bit acc, wr;
    logic [1:0] wa;
    logic [31:0] wd;
    logic [31:0] expRd;
    forever begin
      @(negedge clk); #1;
      if (rstN) begin
        case (regRdAddr)
          2'd0: expRd = mAddr;
          2'd1: expRd = 32'(mRem);
          2'd2: expRd = {30'd0, mDone, (mRem == 0)};
          default: expRd = 32'd0;
        endcase
        check(regRdData === expRd,
              regRdAddr == 0 ? "R2 addr read" : regRdAddr == 1 ? "R9 remaining read" :
              regRdAddr == 2 ? "R11 R10 status read" : "R11 spare read", regRdData, expRd);
        if (mRem == 0) begin
          check(!txValid && !memReq, "R4 R11 idle outputs quiet", {txValid, memReq}, 0);
        end
        if (txValid) begin
          check(expQ.size() > 0 && txData === expQ[0], "R6 byte value", txData,
                expQ.size() > 0 ? expQ[0] : 0);
          check(txLast === (expQ.size() == 1), "R7 last marker", txLast, expQ.size() == 1);
        end
        if (memReq) begin
          check(memAddr === mBase + 32'(((mLen - mRem) / 4) * 4), "R5 fetch address",
                memAddr, mBase + 32'(((mLen - mRem) / 4) * 4));
        end
      end
      acc = txValid && txReady;
      wr = regWrEn; wa = regWrAddr; wd = regWrData;
      @(posedge clk);
      if (!rstN) begin
        expQ.delete(); mRem = 0; mLen = 0; mAddr = 0; mBase = 0; mDone = 0;
      end else begin
        bit setD;
        bit idleBefore;
        setD = 0;
        idleBefore = (mRem == 0);
        if (acc) begin
          if (expQ.size() > 0) void'(expQ.pop_front());
          mRem--;
          if (mRem == 0) setD = 1;
        end
        if (wr && wa == 2'd0 && idleBefore) mAddr = {wd[31:2], 2'b00};
        if (wr && wa == 2'd1 && idleBefore && wd[10:0] != 0) begin
          mLen = int'(wd[10:0]); mRem = mLen; mBase = mAddr;
          for (int k = 0; k < mLen; k++) expQ.push_back(patByte(mAddr + 32'(k)));
        end
        if (setD) mDone = 1;
        else if (wr && wa == 2'd2 && wd[1]) mDone = 0;
      end
    end
  end

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (mRem != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input logic [31:0] a, input int len);
    wrReg(2'd0, a);
    wrReg(2'd1, 32'(len));
    waitIdle();
    wrReg(2'd2, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(!txValid && !memReq, "R1 reset outputs", {txValid, memReq}, 0);
    repeat (4) @(negedge clk);

    readyMode = 0;
    frame(32'h0000_1003, 1);     // R2 alignment, R6 single byte
    frame(32'h0000_2000, 4);
    frame(32'h0000_2100, 5);
    readyMode = 1;
    frame(32'h0000_3000, 6);
    frame(32'h0000_3044, 7);
    readyMode = 2;
    frame(32'h0000_4000, 13);

    // R4 zero length ignored
    wrReg(2'd0, 32'h0000_5000);
    wrReg(2'd1, 32'h0000_0800);  // bits 10:0 zero
    repeat (6) @(negedge clk);
    check(mRem == 0 && !memReq, "R4 zero length ignored", memReq, 0);

    // R4 writes while busy ignored
    readyMode = 1;
    wrReg(2'd1, 32'd9);
    wrReg(2'd0, 32'h0000_7700);
    wrReg(2'd1, 32'd3);
    waitIdle();
    wrReg(2'd1, 32'd2);          // reuses the 0x5000 address
    waitIdle();

    // R10 clear issued while the last byte may be accepted
    readyMode = 0;
    wrReg(2'd1, 32'd1);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = 2'd2; regWrData = 32'h2;
    repeat (6) @(negedge clk);
    regWrEn = 1'b0;
    waitIdle();
    wrReg(2'd2, 32'h2);
    repeat (4) @(negedge clk);

    // maximum length, random stalls
    readyMode = 1;
    frame(32'h0001_0000, 2047);

    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    tests++;
    $display("FAIL watchdog R1 actual=%0d expected=done", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule